// File: doc/BRIEF.md
# PCIe Interrupt Aggregator with Two-Level MSI Status

This block merges the interrupt traffic of a PCIe host bridge into one interrupt line toward the processor. Four legacy INTx level inputs are latched into a local status word. Message-signalled interrupts reach the block as memory writes on a small inbound channel. A write that targets the doorbell address carries a data word that names one of 32 vectors, and the matching bit of a per-vector status register is set.

The local status word holds a summary bit for the MSI side. This bit stays set while any vector is pending. A service routine reads the local status. If the summary bit is up, it reads the vector register, clears each vector it handles, and then clears the summary bit. Both levels clear when a one is written to them, and a local enable register selects which local bits drive the combined interrupt.

The MSI channel uses valid/ready. Ready rises in the first cycle after reset and then stays high, so the channel never applies back-pressure. A write is accepted in every cycle in which valid and ready are both high. The register bus is plain: one-cycle write strobes, and read data that is registered and valid one cycle after the read strobe.

Top module: `irqagg_top`

## Requirements
- R1: An accepted MSI write to address DOORBELL (default 0x40) whose data N is below 32 sets bit N of the vector status register (register offset 0x08) one cycle later.
- R2: An MSI write with data of 32 or more, or with an address other than DOORBELL, changes no status bit.
- R3: Bit 28 of the local status register (offset 0x04) becomes set one cycle after any vector bit is pending. A clear of bit 28 has no effect while any vector bit is set.
- R4: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. The vector register and the local status register are cleared independently of each other.
- R5: Local status bits 27:24 latch the INTx inputs, with INTA at bit 24, one cycle after the input is high. A clear of such a bit takes effect only while its input is low.
- R6: If a capture and a clear reach the same vector in the same cycle, the bit stays set. A clear of another vector in that cycle still takes effect.
- R7: The enable register (offset 0x00) holds bits 28:24 at the positions of the local status bits, where 1 means enabled. Its other bits read as 0.
- R8: irq_o is high exactly when some local status bit and its enable bit are both 1.
- R9: After reset all status bits and all enable bits read 0, and irq_o is low.
- R10: msi_ready_o is high in every cycle after reset. Read data for an offset appears on reg_rdata_o one cycle after the read strobe, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| msi_valid_i | input | 1 | Inbound MSI write valid |
| msi_ready_o | output | 1 | Inbound MSI write ready |
| msi_addr_i | input | 8 | Inbound MSI write address |
| msi_data_i | input | 32 | Inbound MSI data (vector number) |
| intx_i | input | 4 | INTx levels, INTA at bit 0 |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a capture and a software clear that land on the same vector in the same clock edge. The task-based accessors issue one operation at a time, so they cannot produce it. The bench therefore drives the MSI channel and the register write strobe by hand on the same falling edge, with a neighbouring vector pending as well, and then checks that the targeted bit survives while the neighbour is cleared. A second hard case is a clear of the summary bit while vectors are still pending. The stimulus for it leaves a vector set, clears only the summary bit, and reads the local status back.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int REG_AW    = 8;
  localparam int DATA_W    = 32;
  localparam int NUM_INTX  = 4;
  localparam int NUM_VEC   = 32;
  localparam int INTX_LSB  = 24;
  localparam int SUM_BIT   = INTX_LSB + NUM_INTX;

  localparam logic [REG_AW-1:0] OFF_ENABLE = 8'h00;
  localparam logic [REG_AW-1:0] OFF_LSTAT  = 8'h04;
  localparam logic [REG_AW-1:0] OFF_VSTAT  = 8'h08;

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [REG_AW-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } reg_req_t;
endpackage

// File: rtl/irqagg_msi_capture.sv
module irqagg_msi_capture #(
  parameter int NUM_VEC = 32,
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] DOORBELL = 8'h40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      data,
  input  logic [NUM_VEC-1:0] clr_vec,
  input  logic               clr_sum,
  output logic [NUM_VEC-1:0] vec_stat,
  output logic               sum_stat
);
  logic               hit;
  logic [NUM_VEC-1:0] set_vec;

  assign hit = accept && (addr == DOORBELL) && (data < DW'(NUM_VEC));

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_dec
    assign set_vec[v] = hit && (data == DW'(v));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_stat <= '0;
      sum_stat <= 1'b0;
    end else begin
      // a new capture overrides a clear of the same vector
      vec_stat <= (vec_stat & ~clr_vec) | set_vec;
      // summary cannot drop while any vector is still pending
      sum_stat <= (sum_stat & ~clr_sum) | (|vec_stat);
    end
  end
endmodule

// File: rtl/irqagg_intx_capture.sv
module irqagg_intx_capture #(
  parameter int NUM_INTX = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_INTX-1:0] level,
  input  logic [NUM_INTX-1:0] clr,
  output logic [NUM_INTX-1:0] stat
);
  for (genvar k = 0; k < NUM_INTX; k++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) stat[k] <= 1'b0;
      else        stat[k] <= level[k] | (stat[k] & ~clr[k]);
    end
  end
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
  import irqagg_pkg::*;
#(
  parameter int NUM_VEC = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  reg_req_t            req,
  input  logic [NUM_VEC-1:0]  vec_stat,
  input  logic                sum_stat,
  input  logic [NUM_INTX-1:0] intx_stat,
  output logic [NUM_INTX:0]   enable_q,
  output logic [NUM_VEC-1:0]  clr_vec,
  output logic                clr_sum,
  output logic [NUM_INTX-1:0] clr_intx,
  output logic [DATA_W-1:0]   rdata
);
  logic [DATA_W-1:0] lstat_word, enable_word, vstat_word, rd_mux;
  logic wr_lstat, wr_vstat, wr_enable;

  assign wr_enable = req.wr && (req.addr == OFF_ENABLE);
  assign wr_lstat  = req.wr && (req.addr == OFF_LSTAT);
  assign wr_vstat  = req.wr && (req.addr == OFF_VSTAT);

  assign clr_vec  = wr_vstat ? req.wdata[NUM_VEC-1:0] : '0;
  assign clr_intx = wr_lstat ? req.wdata[INTX_LSB +: NUM_INTX] : '0;
  assign clr_sum  = wr_lstat && req.wdata[SUM_BIT];

  always_comb begin
    lstat_word = '0;
    lstat_word[INTX_LSB +: NUM_INTX] = intx_stat;
    lstat_word[SUM_BIT] = sum_stat;
    enable_word = '0;
    enable_word[INTX_LSB +: NUM_INTX + 1] = enable_q;
    vstat_word = '0;
    vstat_word[NUM_VEC-1:0] = vec_stat;
    case (req.addr)
      OFF_ENABLE: rd_mux = enable_word;
      OFF_LSTAT:  rd_mux = lstat_word;
      OFF_VSTAT:  rd_mux = vstat_word;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      rdata    <= '0;
    end else begin
      if (wr_enable) enable_q <= req.wdata[INTX_LSB +: NUM_INTX + 1];
      if (req.rd)    rdata    <= rd_mux;
    end
  end
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter logic [REG_AW-1:0] DOORBELL = 8'h40
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic [REG_AW-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic                msi_valid_i,
  output logic                msi_ready_o,
  input  logic [REG_AW-1:0]   msi_addr_i,
  input  logic [DATA_W-1:0]   msi_data_i,
  input  logic [NUM_INTX-1:0] intx_i,
  output logic                irq_o
);
  reg_req_t            req;
  logic                ready_q;
  logic [NUM_VEC-1:0]  vec_stat, clr_vec;
  logic                sum_stat, clr_sum;
  logic [NUM_INTX-1:0] intx_stat, clr_intx;
  logic [NUM_INTX:0]   enable_q;

  assign req = '{wr: reg_wr_i, rd: reg_rd_i, addr: reg_addr_i, wdata: reg_wdata_i};

  always_ff @(posedge clk_i) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= 1'b1;
  end
  assign msi_ready_o = ready_q;

  irqagg_msi_capture #(
    .NUM_VEC(NUM_VEC), .AW(REG_AW), .DW(DATA_W), .DOORBELL(DOORBELL)
  ) u_msi (
    .clk(clk_i), .rst_n(rst_ni),
    .accept(msi_valid_i && ready_q), .addr(msi_addr_i), .data(msi_data_i),
    .clr_vec(clr_vec), .clr_sum(clr_sum),
    .vec_stat(vec_stat), .sum_stat(sum_stat)
  );

  irqagg_intx_capture #(.NUM_INTX(NUM_INTX)) u_intx (
    .clk(clk_i), .rst_n(rst_ni), .level(intx_i), .clr(clr_intx), .stat(intx_stat)
  );

  irqagg_regs #(.NUM_VEC(NUM_VEC)) u_regs (
    .clk(clk_i), .rst_n(rst_ni), .req(req),
    .vec_stat(vec_stat), .sum_stat(sum_stat), .intx_stat(intx_stat),
    .enable_q(enable_q), .clr_vec(clr_vec), .clr_sum(clr_sum),
    .clr_intx(clr_intx), .rdata(reg_rdata_o)
  );

  assign irq_o = |({sum_stat, intx_stat} & enable_q);
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
  parameter int NUM_VEC = 32,
  parameter int NUM_INTX = 4,
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] DOORBELL = 8'h40
) (
  input logic                clk,
  input logic                rst_n,
  input logic                msi_valid,
  input logic                msi_ready,
  input logic [AW-1:0]       msi_addr,
  input logic [DW-1:0]       msi_data,
  input logic [NUM_INTX-1:0] intx,
  input logic                irq,
  input logic [NUM_INTX:0]   enable_q,
  input logic [NUM_VEC-1:0]  vec_stat,
  input logic                sum_stat,
  input logic [NUM_INTX-1:0] intx_stat
);
  localparam int VW = $clog2(NUM_VEC);

  // R1 and R6: an accepted capture always lands, even against a clear
  assert_capture_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && msi_ready && msi_addr == DOORBELL && msi_data < DW'(NUM_VEC))
      |=> vec_stat[$past(msi_data[VW-1:0])]);

  assert_summary_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|vec_stat) |=> sum_stat);

  assert_intx_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (intx != '0) |=> ((intx_stat & $past(intx)) == $past(intx)));

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (enable_q != '0));

  assert_ready_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    msi_ready |=> msi_ready);
endmodule

bind irqagg_top irqagg_checker #(
  .NUM_VEC(irqagg_pkg::NUM_VEC), .NUM_INTX(irqagg_pkg::NUM_INTX),
  .AW(irqagg_pkg::REG_AW), .DW(irqagg_pkg::DATA_W), .DOORBELL(DOORBELL)
) u_chk (
  .clk(clk_i), .rst_n(rst_ni),
  .msi_valid(msi_valid_i), .msi_ready(msi_ready_o),
  .msi_addr(msi_addr_i), .msi_data(msi_data_i),
  .intx(intx_i), .irq(irq_o), .enable_q(enable_q),
  .vec_stat(vec_stat), .sum_stat(sum_stat), .intx_stat(intx_stat)
);

// File: tb/tb_irqagg_top.sv
`timescale 1ns/100ps
module tb_irqagg_top;
  localparam logic [7:0] DB = 8'h40;
  localparam logic [7:0] A_EN = 8'h00, A_LS = 8'h04, A_VS = 8'h08;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic msi_valid = 0, msi_ready;
  logic [7:0] msi_addr = '0;
  logic [31:0] msi_data = '0;
  logic [3:0] intx = '0;
  logic irq;
  int checks = 0, fails = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  irqagg_top #(.DOORBELL(DB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .msi_valid_i(msi_valid), .msi_ready_o(msi_ready), .msi_addr_i(msi_addr),
    .msi_data_i(msi_data), .intx_i(intx), .irq_o(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rdr(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic msi(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); msi_valid = 1; msi_addr = a; msi_data = d;
    @(negedge clk); msi_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state, R10 ready
    rdr(A_EN, rd); check("R9 enable", rd, 0);
    rdr(A_LS, rd); check("R9 lstat", rd, 0);
    rdr(A_VS, rd); check("R9 vstat", rd, 0);
    check("R9 irq", {31'b0, irq}, 0);
    check("R10 ready", {31'b0, msi_ready}, 1);
    rdr(8'h0C, rd); check("R10 unmapped", rd, 0);

    // R7 enable register fields
    wr(A_EN, 32'hFFFF_FFFF); rdr(A_EN, rd); check("R7 enable mask", rd, 32'h1F00_0000);

    // R1/R3/R4/R8 sweep over all vectors
    for (int v = 0; v < 32; v++) begin
      msi(DB, v);
      rdr(A_VS, rd); check("R1 vector set", rd, 32'h1 << v);
      rdr(A_LS, rd); check("R3 summary set", rd, 32'h1000_0000);
      check("R8 irq on msi", {31'b0, irq}, 1);
      wr(A_VS, 32'h1 << v); wr(A_LS, 32'h1000_0000);
      rdr(A_LS, rd); check("R4 summary cleared", rd, 0);
      check("R8 irq off", {31'b0, irq}, 0);
    end

    // R2 ignored writes
    msi(DB, 32); msi(DB, 32'h8000_0001); msi(8'h44, 3);
    rdr(A_VS, rd); check("R2 vstat unchanged", rd, 0);
    rdr(A_LS, rd); check("R2 lstat unchanged", rd, 0);

    // R3 summary clear refused while vector pending; R4 zero write
    msi(DB, 1); msi(DB, 2);
    wr(A_LS, 32'h1000_0000);
    rdr(A_LS, rd); check("R3 summary held", rd, 32'h1000_0000);
    wr(A_VS, 32'h0); rdr(A_VS, rd); check("R4 zero write", rd, 32'h6);
    wr(A_VS, 32'h2); rdr(A_VS, rd); check("R4 single clear", rd, 32'h4);
    rdr(A_LS, rd); check("R4 independent levels", rd, 32'h1000_0000);

    // R6 capture vs clear in the same cycle
    msi(DB, 5);
    @(negedge clk);
    msi_valid = 1; msi_addr = DB; msi_data = 5;
    reg_wr = 1; reg_addr = A_VS; reg_wdata = 32'h24;
    @(negedge clk); msi_valid = 0; reg_wr = 0;
    rdr(A_VS, rd); check("R6 capture wins", rd, 32'h20);
    wr(A_VS, 32'hFFFF_FFFF); wr(A_LS, 32'hFFFF_FFFF);
    rdr(A_LS, rd); check("R6 cleanup", rd, 0);

    // R5 clear refused while level high
    intx = 4'b0001; @(negedge clk);
    wr(A_LS, 32'h0100_0000);
    rdr(A_LS, rd); check("R5 held while high", rd, 32'h0100_0000);
    intx = 4'b0000; @(negedge clk);
    rdr(A_LS, rd); check("R5 sticky after drop", rd, 32'h0100_0000);
    wr(A_LS, 32'h0100_0000);
    rdr(A_LS, rd); check("R5 cleared when low", rd, 0);

    // R5/R8 sweep of INTx patterns and enable values
    for (int p = 0; p < 16; p++) begin
      intx = 4'(p); @(negedge clk); @(negedge clk);
      rdr(A_LS, rd); check("R5 intx pattern", rd, 32'(p) << 24);
      for (int m = 0; m < 32; m++) begin
        wr(A_EN, 32'(m) << 24);
        check("R8 irq combine", {31'b0, irq}, {31'b0, |(4'(p) & 4'(m))});
      end
      intx = 4'b0; @(negedge clk);
      wr(A_LS, 32'h0F00_0000);
    end
    rdr(A_LS, rd); check("R5 all cleared", rd, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule